// File: doc/BRIEF.md
# NAND bus cycle timing sequencer

This block produces the pin-level strobe pattern for a single access on an asynchronous NAND flash bus. A host presents one request at a time: a region (data, command or address), a direction and a byte or 16-bit word. The sequencer walks the access through four timed phases: setup, wait, hold and bus release. It drives chip enable, the command and address latch enables, the write and read strobes, the data output enable and the data bus. A single-cycle done pulse marks the end of the hold phase.

Two independent phase-count sets are kept. Data accesses take their counts from the common set. Command and address accesses take theirs from the attribute set. A data read that directly follows a command or an address write is preceded by a programmable turnaround, and each of the two cases has its own delay. When enabled, the ready/busy input stretches the wait phase. All configuration is a plain parallel load through a three-way selector.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset chip enable, write strobe and read strobe are high (inactive), both latch enables and the output enable are low, and busy and done are low.
- R2: cfg_sel_i selects the target of a load: 0 is the common set, 1 is the attribute set, 2 is the control word. A phase-count word holds setup in bits 7:0, wait in bits 15:8, hold in bits 23:16 and bus release in bits 31:24. Both sets reset to 0x0A0A0A0A.
- R3: Region code 0 (data; code 3 behaves as data) uses the common set. Codes 1 (command) and 2 (address) use the attribute set.
- R4: Chip enable is low for exactly setup+wait+hold cycles (plus any turnaround), and the strobe for the direction is low only during the wait cycles. busy_o is high for the whole access, including bus release.
- R5: A setup, wait or hold count of 0 behaves as 1. A bus-release count of 0 means no release cycles.
- R6: A command access raises cle_o and an address access raises ale_o while chip enable is low. Both place one byte on dq_o[7:0], with the upper bits zero.
- R7: For writes, the output enable is high from setup through hold and low from bus release onward. It is never high for reads.
- R8: done_o is high for exactly one cycle, the cycle right after the last hold cycle.
- R9: Control word bits 3:0 hold the command-to-read delay and bits 7:4 hold the address-to-read delay. Both reset to 15. A data read whose previous accepted access was a command (or an address) holds chip enable low for that many extra cycles before setup. No turnaround is added otherwise.
- R10: When control bit 10 (wait enable) is set, a low rb_i holds the wait phase past its count until rb_i is sampled high. When the bit is clear, rb_i has no effect.
- R11: Control bits 9:8 select the bus width: 0 is 8-bit and 1 is 16-bit. In 8-bit mode data bytes travel on bits 7:0 with the upper bits zero. Read data is captured from dq_i at the last wait cycle and held on rdata_o.
- R12: A request presented while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration load strobe |
| cfg_sel_i | input | 2 | Load target: 0 common set, 1 attribute set, 2 control |
| cfg_data_i | input | 32 | Configuration value |
| req_valid_i | input | 1 | Access request, taken when idle |
| req_region_i | input | 2 | 0 data, 1 command, 2 address |
| req_write_i | input | 1 | 1 write, 0 read |
| req_wdata_i | input | 16 | Write data, command or address byte |
| rb_i | input | 1 | Device ready (high) / busy (low) |
| dq_i | input | 16 | Data bus input |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle pulse after hold |
| rdata_o | output | 16 | Captured read data |
| dq_o | output | 16 | Data bus output value |
| dq_oe_o | output | 1 | Data bus output enable |
| ce_no | output | 1 | Chip enable, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no | output | 1 | Write strobe, active low |
| re_no | output | 1 | Read strobe, active low |

## Verification
The phase machine is run with the reset counts, with distinct counts in each field of the attribute set, and with all-zero counts. Comparing cycle totals of chip enable, strobe and busy tells apart a swapped field, a wrong set choice and a missing clamp. Reads are issued after a command, after an address and after another read, which separates the two turnaround delays from the no-turnaround case. Wait stretching is tried with the enable both set and clear, while ready is held low. Width handling is tried with a 16-bit pattern in both width modes.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  parameter int unsigned PH_CNT_W = 8;
  parameter int unsigned DLY_W    = 4;
  localparam int unsigned TSET_W  = 4 * PH_CNT_W;

  typedef logic [PH_CNT_W-1:0] cnt_t;

  // field order gives setup at the low byte, release at the top
  typedef struct packed {
    cnt_t rel;
    cnt_t hold;
    cnt_t wt;
    cnt_t setup;
  } ph_times_t;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CMD  = 2'd1,
    REG_ADDR = 2'd2,
    REG_RSVD = 2'd3
  } region_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_TURN, PH_SETUP, PH_WAIT, PH_HOLD, PH_REL
  } phase_e;

  localparam ph_times_t TIMES_RST = {4{PH_CNT_W'(10)}};

  function automatic cnt_t at_least_one(cnt_t c);
    return (c == '0) ? cnt_t'(1) : c;
  endfunction

  function automatic logic is_data(region_e r);
    return (r != REG_CMD) && (r != REG_ADDR);
  endfunction
endpackage

// File: rtl/nand_timing_regs.sv
module nand_timing_regs
  import nand_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [TSET_W-1:0] cfg_data_i,
  output ph_times_t         com_o,
  output ph_times_t         att_o,
  output logic [DLY_W-1:0]  cle_dly_o,
  output logic [DLY_W-1:0]  ale_dly_o,
  output logic              wide_o,
  output logic              wait_en_o
);
  localparam int unsigned WID_LSB = 2 * DLY_W;
  localparam int unsigned WEN_BIT = WID_LSB + 2;

  logic [1:0] wid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      com_o     <= TIMES_RST;
      att_o     <= TIMES_RST;
      cle_dly_o <= '1;
      ale_dly_o <= '1;
      wid_q     <= 2'd0;
      wait_en_o <= 1'b0;
    end else if (cfg_we_i) begin
      case (cfg_sel_i)
        2'd0: com_o <= ph_times_t'(cfg_data_i);
        2'd1: att_o <= ph_times_t'(cfg_data_i);
        2'd2: begin
          cle_dly_o <= cfg_data_i[DLY_W-1:0];
          ale_dly_o <= cfg_data_i[2*DLY_W-1:DLY_W];
          wid_q     <= cfg_data_i[WID_LSB+1:WID_LSB];
          wait_en_o <= cfg_data_i[WEN_BIT];
        end
        default: ;
      endcase
    end
  end

  assign wide_o = (wid_q == 2'd1);
endmodule

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
  import nand_seq_pkg::*;
#(
  parameter int unsigned DQ_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  region_e          req_region_i,
  input  logic             req_write_i,
  input  logic [DQ_W-1:0]  req_wdata_i,
  input  logic             rb_i,
  input  ph_times_t        com_i,
  input  ph_times_t        att_i,
  input  logic [DLY_W-1:0] cle_dly_i,
  input  logic [DLY_W-1:0] ale_dly_i,
  input  logic             wait_en_i,
  output phase_e           phase_o,
  output region_e          cur_region_o,
  output logic             cur_write_o,
  output logic [DQ_W-1:0]  cur_wdata_o,
  output logic             sample_o,
  output logic             done_o
);
  cnt_t      cnt_q;
  region_e   last_q;
  ph_times_t req_set, cur_set;
  logic [DLY_W-1:0] turn_len;
  logic      stall, wait_end;

  assign req_set  = is_data(req_region_i) ? com_i : att_i;
  assign cur_set  = is_data(cur_region_o) ? com_i : att_i;
  assign turn_len = (last_q == REG_CMD)  ? cle_dly_i :
                    (last_q == REG_ADDR) ? ale_dly_i : '0;
  assign stall    = wait_en_i && !rb_i;
  assign wait_end = (phase_o == PH_WAIT) && (cnt_q == '0) && !stall;
  assign sample_o = wait_end && !cur_write_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o      <= PH_IDLE;
      cnt_q        <= '0;
      last_q       <= REG_DATA;
      cur_region_o <= REG_DATA;
      cur_write_o  <= 1'b0;
      cur_wdata_o  <= '0;
      done_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (phase_o)
        PH_IDLE: if (req_valid_i) begin
          cur_region_o <= req_region_i;
          cur_write_o  <= req_write_i;
          cur_wdata_o  <= req_wdata_i;
          last_q       <= is_data(req_region_i) ? REG_DATA : req_region_i;
          if (!req_write_i && is_data(req_region_i) && (turn_len != '0)) begin
            phase_o <= PH_TURN;
            cnt_q   <= cnt_t'(turn_len) - cnt_t'(1);
          end else begin
            phase_o <= PH_SETUP;
            cnt_q   <= at_least_one(req_set.setup) - cnt_t'(1);
          end
        end
        PH_TURN:
          if (cnt_q == '0) begin
            phase_o <= PH_SETUP;
            cnt_q   <= at_least_one(cur_set.setup) - cnt_t'(1);
          end else cnt_q <= cnt_q - cnt_t'(1);
        PH_SETUP:
          if (cnt_q == '0) begin
            phase_o <= PH_WAIT;
            cnt_q   <= at_least_one(cur_set.wt) - cnt_t'(1);
          end else cnt_q <= cnt_q - cnt_t'(1);
        PH_WAIT:
          if (wait_end) begin
            phase_o <= PH_HOLD;
            cnt_q   <= at_least_one(cur_set.hold) - cnt_t'(1);
          end else if (cnt_q != '0) cnt_q <= cnt_q - cnt_t'(1);
        PH_HOLD:
          if (cnt_q == '0) begin
            done_o <= 1'b1;
            if (cur_set.rel == '0) phase_o <= PH_IDLE;
            else begin
              phase_o <= PH_REL;
              cnt_q   <= cur_set.rel - cnt_t'(1);
            end
          end else cnt_q <= cnt_q - cnt_t'(1);
        PH_REL:
          if (cnt_q == '0) phase_o <= PH_IDLE;
          else cnt_q <= cnt_q - cnt_t'(1);
        default: phase_o <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_pin_drive.sv
module nand_pin_drive
  import nand_seq_pkg::*;
#(
  parameter int unsigned DQ_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  phase_e          phase_i,
  input  region_e         region_i,
  input  logic            write_i,
  input  logic [DQ_W-1:0] wdata_i,
  input  logic            wide_i,
  input  logic            sample_i,
  input  logic [DQ_W-1:0] dq_i,
  output logic [DQ_W-1:0] rdata_o,
  output logic [DQ_W-1:0] dq_o,
  output logic            dq_oe_o,
  output logic            ce_no,
  output logic            cle_o,
  output logic            ale_o,
  output logic            we_no,
  output logic            re_no,
  output logic            busy_o
);
  localparam int unsigned BYTE_W = 8;

  logic sel, drive, strobe, byte_only;

  assign sel       = (phase_i == PH_TURN) || (phase_i == PH_SETUP) ||
                     (phase_i == PH_WAIT) || (phase_i == PH_HOLD);
  assign drive     = (phase_i == PH_SETUP) || (phase_i == PH_WAIT) ||
                     (phase_i == PH_HOLD);
  assign strobe    = (phase_i == PH_WAIT);
  assign byte_only = !is_data(region_i) || !wide_i;

  assign ce_no   = !sel;
  assign cle_o   = sel && (region_i == REG_CMD);
  assign ale_o   = sel && (region_i == REG_ADDR);
  assign we_no   = !(strobe && write_i);
  assign re_no   = !(strobe && !write_i);
  assign dq_oe_o = drive && write_i;
  assign busy_o  = (phase_i != PH_IDLE);
  assign dq_o    = !write_i  ? '0 :
                   byte_only ? DQ_W'(wdata_i[BYTE_W-1:0]) : wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (sample_i)
      rdata_o <= byte_only ? DQ_W'(dq_i[BYTE_W-1:0]) : dq_i;
  end
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int unsigned DQ_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [TSET_W-1:0] cfg_data_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_region_i,
  input  logic              req_write_i,
  input  logic [DQ_W-1:0]   req_wdata_i,
  input  logic              rb_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DQ_W-1:0]   rdata_o,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  output logic              ce_no,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no
);
  ph_times_t        com, att;
  logic [DLY_W-1:0] cle_dly, ale_dly;
  logic             wide, wait_en, sample, cur_write;
  phase_e           phase;
  region_e          cur_region;
  logic [DQ_W-1:0]  cur_wdata;

  nand_timing_regs u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_data_i,
    .com_o(com), .att_o(att), .cle_dly_o(cle_dly), .ale_dly_o(ale_dly),
    .wide_o(wide), .wait_en_o(wait_en)
  );

  nand_phase_fsm #(.DQ_W(DQ_W)) u_fsm (
    .clk_i, .rst_ni, .req_valid_i,
    .req_region_i(region_e'(req_region_i)),
    .req_write_i, .req_wdata_i, .rb_i,
    .com_i(com), .att_i(att), .cle_dly_i(cle_dly), .ale_dly_i(ale_dly),
    .wait_en_i(wait_en),
    .phase_o(phase), .cur_region_o(cur_region), .cur_write_o(cur_write),
    .cur_wdata_o(cur_wdata), .sample_o(sample), .done_o
  );

  nand_pin_drive #(.DQ_W(DQ_W)) u_pins (
    .clk_i, .rst_ni, .phase_i(phase), .region_i(cur_region),
    .write_i(cur_write), .wdata_i(cur_wdata), .wide_i(wide),
    .sample_i(sample), .dq_i, .rdata_o, .dq_o, .dq_oe_o,
    .ce_no, .cle_o, .ale_o, .we_no, .re_no, .busy_o
  );
endmodule

// File: rtl/nand_cycle_seq_chk.sv
module nand_cycle_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic dq_oe_o,
  input logic ce_no,
  input logic cle_o,
  input logic ale_o,
  input logic we_no,
  input logic re_no
);
  // R4
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));
  // R4
  strobe_in_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no || !re_no) |-> !ce_no);
  // R6
  latch_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  // R7
  oe_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (!ce_no && re_no));
  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_after_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(!ce_no) && ce_no));
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ce_no && we_no && re_no && !dq_oe_o && !cle_o && !ale_o));
endmodule

bind nand_cycle_seq nand_cycle_seq_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .dq_oe_o(dq_oe_o), .ce_no(ce_no), .cle_o(cle_o), .ale_o(ale_o),
  .we_no(we_no), .re_no(re_no)
);

// File: tb/nand_cycle_seq_tb_top.sv
module nand_cycle_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = 2'd0;
  logic [31:0] cfg_data_i = '0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_region_i = 2'd0;
  logic        req_write_i = 1'b0;
  logic [15:0] req_wdata_i = '0;
  logic        rb_i = 1'b1;
  logic [15:0] dq_i = 16'hC3A7;
  logic        busy_o, done_o, dq_oe_o, ce_no, cle_o, ale_o, we_no, re_no;
  logic [15:0] rdata_o, dq_o;

  int total = 0, bad = 0;
  int n_ce, n_cle, n_ale, n_we, n_re, n_oe, n_busy, n_done, done_idx;
  logic [15:0] dq_seen;

  always #5 clk_i = ~clk_i;

  nand_cycle_seq dut_i (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic cfg(int sel, logic [31:0] val);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = 2'(sel); cfg_data_i = val;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // issue one access and measure pin activity cycle by cycle
  task automatic run(int region, bit wr, logic [15:0] wd, int rel_at, bit poke);
    n_ce = 0; n_cle = 0; n_ale = 0; n_we = 0; n_re = 0; n_oe = 0;
    n_busy = 0; n_done = 0; done_idx = -1; dq_seen = '0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_region_i = 2'(region); req_write_i = wr; req_wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      if (!ce_no) n_ce++;
      if (cle_o) n_cle++;
      if (ale_o) n_ale++;
      if (!we_no) begin n_we++; dq_seen = dq_o; end
      if (!re_no) n_re++;
      if (dq_oe_o) n_oe++;
      if (busy_o) n_busy++;
      if (done_o) begin n_done++; if (done_idx < 0) done_idx = k; end
      if (rel_at > 0 && (n_we + n_re) == rel_at) rb_i = 1'b1;
      req_valid_i = poke && (k == 2);
      req_region_i = poke ? 2'd1 : req_region_i;
      if (!busy_o) break;
      @(negedge clk_i);
    end
    req_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ce_no", ce_no, 1); chk("R1 we_no", we_no, 1);
    chk("R1 re_no", re_no, 1); chk("R1 cle", cle_o, 0);
    chk("R1 ale", ale_o, 0);   chk("R1 oe", dq_oe_o, 0);
    chk("R1 busy", busy_o, 0); chk("R1 done", done_o, 0);
  endtask

  task automatic t_defaults;
    run(0, 1, 16'hA55A, 0, 0);
    chk("R2 default ce", n_ce, 30);  chk("R4 we", n_we, 10);
    chk("R4 re", n_re, 0);           chk("R4 busy", n_busy, 40);
    chk("R7 oe", n_oe, 30);          chk("R8 done count", n_done, 1);
    chk("R8 done idx", done_idx, 30); chk("R11 byte dq", dq_seen, 16'h005A);
    chk("R6 no cle on data", n_cle, 0);
    run(1, 1, 16'h0070, 0, 0);
    chk("R6 cle", n_cle, 30); chk("R6 cmd byte", dq_seen, 16'h0070);
    run(0, 0, 16'h0, 0, 0);
    chk("R9 default cmd turn ce", n_ce, 45); chk("R9 re", n_re, 10);
    chk("R9 busy", n_busy, 55);          chk("R7 read no oe", n_oe, 0);
    chk("R11 byte read", rdata_o, 16'h00A7);
  endtask

  task automatic t_attr;
    cfg(1, 32'h01020304);
    cfg(0, 32'h02020202);
    cfg(2, 32'h00000063);
    run(1, 1, 16'h0090, 0, 0);
    chk("R3 attr ce", n_ce, 9); chk("R3 cle", n_cle, 9);
    chk("R3 we", n_we, 3);      chk("R3 busy", n_busy, 10);
    chk("R3 ale", n_ale, 0);
    run(2, 1, 16'h3412, 0, 0);
    chk("R6 ale", n_ale, 9); chk("R6 addr byte", dq_seen, 16'h0012);
    run(0, 0, 16'h0, 0, 0);
    chk("R9 addr turn ce", n_ce, 12); chk("R3 common re", n_re, 2);
    chk("R9 addr turn busy", n_busy, 14);
    run(0, 0, 16'h0, 0, 0);
    chk("R9 no turn after read", n_ce, 6);
    run(1, 1, 16'h0080, 0, 0);
    run(0, 1, 16'h1111, 0, 0);
    chk("R9 no turn on write", n_ce, 6); chk("R7 oe", n_oe, 6);
    run(1, 1, 16'h0080, 0, 0);
    run(0, 0, 16'h0, 0, 0);
    chk("R9 cmd turn ce", n_ce, 9);
  endtask

  task automatic t_min;
    cfg(0, 32'h00000000);
    run(0, 1, 16'h00FF, 0, 0);
    chk("R5 ce", n_ce, 3); chk("R5 we", n_we, 1);
    chk("R5 busy", n_busy, 3); chk("R5 done idx", done_idx, 3);
  endtask

  task automatic t_width;
    cfg(0, 32'h02020202);
    cfg(2, 32'h00000163);
    run(0, 1, 16'hBEEF, 0, 0);
    chk("R11 wide dq", dq_seen, 16'hBEEF);
    run(1, 1, 16'hAB90, 0, 0);
    chk("R11 cmd stays byte", dq_seen, 16'h0090);
    run(0, 0, 16'h0, 0, 0);
    chk("R11 wide read", rdata_o, 16'hC3A7);
  endtask

  task automatic t_wait;
    cfg(0, 32'h00010301);
    cfg(2, 32'h00000463);
    rb_i = 1'b0;
    run(0, 1, 16'h0001, 10, 0);
    chk("R10 stretched we", n_we, 10); chk("R10 stretched ce", n_ce, 12);
    cfg(2, 32'h00000063);
    rb_i = 1'b0;
    run(0, 1, 16'h0002, 0, 0);
    chk("R10 ignored rb we", n_we, 3);
    rb_i = 1'b1;
  endtask

  task automatic t_busy_ignore;
    cfg(0, 32'h02020202);
    run(0, 1, 16'h0003, 0, 1);
    chk("R12 busy len", n_busy, 8); chk("R12 no cle", n_cle, 0);
    n_busy = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      if (busy_o) n_busy++;
    end
    chk("R12 no second access", n_busy, 0);
  endtask

  initial begin
    for (int k = 0; k < 150000; k++) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_defaults;
    t_attr;
    t_min;
    t_width;
    t_wait;
    t_busy_ignore;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule